// File: doc/BRIEF.md
# Single-Pin GPIO Cell with Debounce and Interrupt Detection

This block is one general-purpose I/O pin. Software reaches it through a small 32-bit register window and uses it to do four things:
- enable the pin;
- choose whether the pin drives or receives;
- float or drive the pad output buffer, and set the level it drives;
- read the level seen on the pad.

The incoming pad level passes through a two-flop synchronizer and then an optional debounce filter. The filter counts an external 1 ms tick, so its threshold is a number of milliseconds.

The filtered level feeds an interrupt detector. The detector has four trigger types: none, level, single edge and double edge. A polarity bit sets which level or which edge direction counts. Detected conditions set a sticky pending bit. Software clears that bit through a write-one-to-clear register. The interrupt output is the pending bit gated by an interrupt-enable bit, so a condition that occurs while masked is still recorded. Pad electrical behaviour and routing of the interrupt across the system are outside this block.

Top module: `pin_io_cell`

## Requirements
- R1: After reset the registers read as follows: configuration (offset 0x00) reads 0, threshold (0x04) reads 0, driver control (0x0C) reads 1 (buffer floated), drive level (0x10) reads 0. After reset `pad_oe` and `irq_out` are 0.
- R2: `pad_oe` is 1 only when three conditions hold: configuration bit 0 (pin enable) is 1, configuration bit 1 (output direction) is 1, and bit 0 of 0x0C (float) is 0.
- R3: `pad_out` equals bit 0 of the drive-level register at 0x10 from the cycle after that register is written.
- R4: Reading offset 0x08 returns the filtered pad level in bit 0. All other bits read 0.
- R5: Trigger type 2 (configuration bits 3:2) detects single edges. With polarity bit 4 set it detects rising edges only. With bit 4 clear it detects falling edges only.
- R6: Trigger type 3 detects both edge directions and ignores the polarity bit.
- R7: Trigger type 1 detects levels: polarity 1 means active high, polarity 0 means active low. While the level stays active, pending is set again on the cycle after a clear, so it cannot be cleared.
- R8: Writing 0x14 with bit 0 set clears the pending bit. A write to 0x14 with bit 0 clear leaves the pending bit unchanged.
- R9: `irq_out` is the pending bit ANDed with configuration bit 6. Conditions detected while bit 6 is 0 still set the pending bit, and `irq_out` rises once bit 6 is set.
- R10: No condition sets the pending bit while the pin enable (bit 0) is 0, or while the trigger type is 0.
- R11: When configuration bit 5 is set and the 8-bit threshold N at 0x04 is nonzero, the filtered level takes a new value only after the synchronized input has differed from it for N consecutive `tick_1ms` pulses. A shorter excursion is discarded.
- R12: When bit 5 is clear, or when the threshold is 0, the synchronized input passes to the filtered level without waiting for ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register window |
| reg_addr | input | 5 | Byte offset of the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 1 | Raw level from the pad |
| pad_out | output | 1 | Level to drive on the pad |
| pad_oe | output | 1 | Pad output driver enable |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| irq_out | output | 1 | Interrupt request |

## Verification
The interrupt detector is exercised with the following patterns, each chosen to separate modes that could be confused:
- A rising transition followed by a falling one, under each trigger type and polarity. This separates rising-only, falling-only and both-edge detection.
- A level held through a clear. This distinguishes level mode, where pending reappears, from edge mode, where it stays cleared.
- An edge taken while the interrupt is masked, and an edge taken while the pin is disabled. The first shows that latching is independent of the enable bit; the second shows that the pin enable blocks detection.

The filter is tried with two pulses:
- A pulse lasting fewer ticks than the threshold, which must be discarded.
- A pulse lasting exactly the threshold, which must be accepted.

Threshold zero and the debounce bit cleared are tried as the two bypass paths.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF   = 2'd0,
      TRIG_LEVEL = 2'd1,
      TRIG_EDGE  = 2'd2,
      TRIG_BOTH  = 2'd3
   } trig_e;

   // Packed MSB first: [6] irq enable, [5] debounce, [4] polarity,
   // [3:2] trigger type, [1] output direction, [0] pin enable
   typedef struct packed {
      logic  irq_en;
      logic  dbnc_en;
      logic  pol;
      trig_e trig;
      logic  dir_out;
      logic  en;
   } pin_cfg_t;

   localparam int unsigned CFG_W    = $bits(pin_cfg_t);

   localparam int unsigned OFF_CFG  = 'h00;
   localparam int unsigned OFF_DBNC = 'h04;
   localparam int unsigned OFF_IN   = 'h08;
   localparam int unsigned OFF_FLT  = 'h0C;
   localparam int unsigned OFF_DRV  = 'h10;
   localparam int unsigned OFF_CLR  = 'h14;

endpackage

// File: rtl/pin_io_regs.sv
module pin_io_regs
   import pin_io_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int THRESH_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic                filt_level,
   output pin_cfg_t            cfg_q,
   output logic [THRESH_W-1:0] thresh_q,
   output logic                float_q,
   output logic                drive_q,
   output logic                clr_pulse
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_DBNC = ADDR_W'(OFF_DBNC);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
   localparam logic [ADDR_W-1:0] A_FLT  = ADDR_W'(OFF_FLT);
   localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFF_DRV);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);

   if (ADDR_W < 5) begin : g_addr_chk
      $error("pin_io_regs: ADDR_W must reach offset 0x14");
   end
   if (THRESH_W > DATA_W || CFG_W > DATA_W) begin : g_width_chk
      $error("pin_io_regs: fields wider than the data bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         thresh_q <= '0;
         float_q  <= 1'b1;
         drive_q  <= 1'b0;
      end else if (wr_en) begin
         unique case (addr)
            A_CFG:   cfg_q    <= pin_cfg_t'(wdata[CFG_W-1:0]);
            A_DBNC:  thresh_q <= wdata[THRESH_W-1:0];
            A_FLT:   float_q  <= wdata[0];
            A_DRV:   drive_q  <= wdata[0];
            default: ;
         endcase
      end
   end

   assign clr_pulse = wr_en && (addr == A_CLR) && wdata[0];

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CFG:   rdata[CFG_W-1:0]    = cfg_q;
         A_DBNC:  rdata[THRESH_W-1:0] = thresh_q;
         A_IN:    rdata[0]            = filt_level;
         A_FLT:   rdata[0]            = float_q;
         A_DRV:   rdata[0]            = drive_q;
         default: rdata               = '0;
      endcase
   end

endmodule

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_stage_chk
      $error("pin_io_sync: at least two stages required");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pin_io_debounce.sv
module pin_io_debounce #(
   parameter int THRESH_W   = 8,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                tick,
   input  logic [THRESH_W-1:0] thresh,
   input  logic                din,
   output logic                dout
);

   if (THRESH_W < 1) begin : g_w_chk
      $error("pin_io_debounce: THRESH_W must be positive");
   end

   if (HAS_FILTER) begin : g_filter
      logic [THRESH_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout <= 1'b0;
            cnt  <= '0;
         end else if (!active || din == dout) begin
            dout <= din;
            cnt  <= '0;
         end else if (tick) begin
            if (cnt + 1'b1 == thresh) begin
               dout <= din;
               cnt  <= '0;
            end else begin
               cnt  <= cnt + 1'b1;
            end
         end
      end
   end else begin : g_bypass
      logic unused_ok;
      assign unused_ok = active ^ tick ^ (^thresh);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= 1'b0;
         else        dout <= din;
      end
   end

endmodule

// File: rtl/pin_io_irq.sv
module pin_io_irq
   import pin_io_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  trig_e trig,
   input  logic  pol,
   input  logic  level,
   input  logic  clr,
   output logic  pend
);

   logic prev;
   logic rise, fall, evt;

   assign rise = level & ~prev;
   assign fall = ~level & prev;

   always_comb begin
      unique case (trig)
         TRIG_OFF:   evt = 1'b0;
         TRIG_LEVEL: evt = (level == pol);
         TRIG_EDGE:  evt = pol ? rise : fall;
         TRIG_BOTH:  evt = rise | fall;
         default:    evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         pend <= 1'b0;
      end else begin
         prev <= level;
         pend <= (pend & ~clr) | (en & evt);
      end
   end

endmodule

// File: rtl/pin_io_cell.sv
module pin_io_cell
   import pin_io_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int THRESH_W    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_DEBOUNCE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   input  logic              tick_1ms,
   output logic              irq_out
);

   pin_cfg_t            cfg_q;
   logic [THRESH_W-1:0] thresh_q;
   logic                float_q;
   logic                drive_q;
   logic                clr_pulse;
   logic                sync_lvl;
   logic                filt_lvl;
   logic                dbnc_on;
   logic                pend_q;

   pin_io_regs #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .THRESH_W(THRESH_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .filt_level(filt_lvl),
      .cfg_q     (cfg_q),
      .thresh_q  (thresh_q),
      .float_q   (float_q),
      .drive_q   (drive_q),
      .clr_pulse (clr_pulse)
   );

   pin_io_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (sync_lvl)
   );

   assign dbnc_on = HAS_DEBOUNCE && cfg_q.dbnc_en && (thresh_q != '0);

   pin_io_debounce #(
      .THRESH_W  (THRESH_W),
      .HAS_FILTER(HAS_DEBOUNCE)
   ) dbnc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .active(dbnc_on),
      .tick  (tick_1ms),
      .thresh(thresh_q),
      .din   (sync_lvl),
      .dout  (filt_lvl)
   );

   pin_io_irq irq_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cfg_q.en),
      .trig (cfg_q.trig),
      .pol  (cfg_q.pol),
      .level(filt_lvl),
      .clr  (clr_pulse),
      .pend (pend_q)
   );

   assign pad_out = drive_q;
   assign pad_oe  = cfg_q.en & cfg_q.dir_out & ~float_q;
   assign irq_out = pend_q & cfg_q.irq_en;

endmodule

// File: rtl/pin_io_cell_chk.sv
module pin_io_cell_chk
   import pin_io_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              pad_out,
   input logic              pad_oe,
   input logic              tick_1ms,
   input logic              irq_out,
   input pin_cfg_t          cfg,
   input logic              filt,
   input logic              dbnc_on,
   input logic              pend
);

   // R2
   float_blocks_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFF_FLT) && reg_wdata[0]) |=> !pad_oe);

   // R3
   drive_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFF_DRV)) |=> (pad_out == $past(reg_wdata[0])));

   // R9
   mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFF_CFG) && !reg_wdata[6]) |=> !irq_out);

   // R10
   pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(cfg.en) && $past(cfg.trig) != TRIG_OFF));

   // R8
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFF_CLR) && reg_wdata[0] && cfg.trig == TRIG_OFF)
      |=> !pend);

   // R11
   filter_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dbnc_on) && filt != $past(filt)) |-> $past(tick_1ms));

endmodule

bind pin_io_cell pin_io_cell_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr_en(reg_wr_en),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .tick_1ms (tick_1ms),
   .irq_out  (irq_out),
   .cfg      (cfg_q),
   .filt     (filt_lvl),
   .dbnc_on  (dbnc_on),
   .pend     (pend_q)
);

// File: tb/pin_io_cell_tb_top.sv
`timescale 1ns/1ps
module pin_io_cell_tb_top;

   localparam int DW = 32;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          pad_in = 1'b0;
   logic          pad_out;
   logic          pad_oe;
   logic          tick_1ms = 1'b0;
   logic          irq_out;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   pin_io_cell dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr_en(reg_wr_en),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .tick_1ms (tick_1ms),
      .irq_out  (irq_out)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
   endtask

   task automatic arm(input logic [DW-1:0] cfg, input logic lvl);
      pad_in = lvl;
      wr(5'h00, cfg);
      cycles(6);
      wr(5'h14, 32'h1);
      cycles(2);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(5'h00, d); check(d, 32'h0, "R1 cfg");
      rd(5'h04, d); check(d, 32'h0, "R1 thresh");
      rd(5'h0C, d); check(d, 32'h1, "R1 float");
      rd(5'h10, d); check(d, 32'h0, "R1 drive");
      check(pad_oe, 1'b0, "R1 pad_oe");
      check(irq_out, 1'b0, "R1 irq_out");
   endtask

   task automatic t_output();
      wr(5'h10, 32'h1);
      check(pad_out, 1'b1, "R3 drive high");
      wr(5'h00, 32'h3);
      check(pad_oe, 1'b0, "R2 floated");
      wr(5'h0C, 32'h0);
      check(pad_oe, 1'b1, "R2 driving");
      wr(5'h10, 32'h0);
      check(pad_out, 1'b0, "R3 drive low");
      wr(5'h00, 32'h1);
      check(pad_oe, 1'b0, "R2 input dir");
      wr(5'h00, 32'h2);
      check(pad_oe, 1'b0, "R2 disabled");
      wr(5'h0C, 32'h1);
   endtask

   task automatic t_input();
      logic [DW-1:0] d;
      wr(5'h00, 32'h1);
      pad_in = 1'b1; cycles(5);
      rd(5'h08, d); check(d, 32'h1, "R4 high");
      pad_in = 1'b0; cycles(5);
      rd(5'h08, d); check(d, 32'h0, "R4 low");
   endtask

   task automatic t_single_edge();
      arm(32'h59, 1'b0);
      check(irq_out, 1'b0, "R5 idle");
      pad_in = 1'b1; cycles(6);
      check(irq_out, 1'b1, "R5 rising seen");
      wr(5'h14, 32'h0); cycles(1);
      check(irq_out, 1'b1, "R8 zero write ignored");
      wr(5'h14, 32'h1); cycles(1);
      check(irq_out, 1'b0, "R8 cleared");
      pad_in = 1'b0; cycles(6);
      check(irq_out, 1'b0, "R5 falling ignored in rising mode");
      arm(32'h49, 1'b1);
      pad_in = 1'b0; cycles(6);
      check(irq_out, 1'b1, "R5 falling seen");
      wr(5'h14, 32'h1);
      pad_in = 1'b1; cycles(6);
      check(irq_out, 1'b0, "R5 rising ignored in falling mode");
   endtask

   task automatic t_double_edge();
      for (int p = 0; p < 2; p++) begin
         arm(p ? 32'h5D : 32'h4D, 1'b0);
         pad_in = 1'b1; cycles(6);
         check(irq_out, 1'b1, "R6 rise");
         wr(5'h14, 32'h1); cycles(1);
         check(irq_out, 1'b0, "R6 cleared");
         pad_in = 1'b0; cycles(6);
         check(irq_out, 1'b1, "R6 fall");
      end
   endtask

   task automatic t_level();
      arm(32'h55, 1'b0);
      check(irq_out, 1'b0, "R7 high inactive");
      pad_in = 1'b1; cycles(6);
      check(irq_out, 1'b1, "R7 high active");
      wr(5'h14, 32'h1); cycles(2);
      check(irq_out, 1'b1, "R7 re-set while active");
      pad_in = 1'b0; cycles(6);
      wr(5'h14, 32'h1); cycles(2);
      check(irq_out, 1'b0, "R7 clears once inactive");
      arm(32'h45, 1'b1);
      check(irq_out, 1'b0, "R7 low inactive");
      pad_in = 1'b0; cycles(6);
      check(irq_out, 1'b1, "R7 low active");
   endtask

   task automatic t_mask();
      arm(32'h19, 1'b0);
      pad_in = 1'b1; cycles(6);
      check(irq_out, 1'b0, "R9 masked");
      wr(5'h00, 32'h59);
      check(irq_out, 1'b1, "R9 latched while masked");
   endtask

   task automatic t_disabled();
      arm(32'h58, 1'b0);
      pad_in = 1'b1; cycles(6);
      wr(5'h00, 32'h59);
      check(irq_out, 1'b0, "R10 pin disabled");
      arm(32'h41, 1'b0);
      pad_in = 1'b1; cycles(6);
      pad_in = 1'b0; cycles(6);
      check(irq_out, 1'b0, "R10 trigger none");
   endtask

   task automatic t_debounce();
      logic [DW-1:0] d;
      pad_in = 1'b0;
      wr(5'h00, 32'h1); cycles(6);
      wr(5'h04, 32'd3);
      wr(5'h00, 32'h21);
      pad_in = 1'b1; cycles(20);
      rd(5'h08, d); check(d, 32'h0, "R11 no ticks no change");
      tick(); tick(); cycles(3);
      rd(5'h08, d); check(d, 32'h0, "R11 two ticks short");
      pad_in = 1'b0; cycles(5);
      pad_in = 1'b1; cycles(5);
      tick(); tick(); cycles(3);
      rd(5'h08, d); check(d, 32'h0, "R11 glitch restarted count");
      tick(); cycles(3);
      rd(5'h08, d); check(d, 32'h1, "R11 third tick accepts");
      wr(5'h04, 32'd0);
      pad_in = 1'b0; cycles(5);
      rd(5'h08, d); check(d, 32'h0, "R12 zero threshold bypass");
      wr(5'h04, 32'd3);
      wr(5'h00, 32'h1);
      pad_in = 1'b1; cycles(5);
      rd(5'h08, d); check(d, 32'h1, "R12 debounce off bypass");
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_output();
      t_input();
      t_single_edge();
      t_double_edge();
      t_level();
      t_mask();
      t_disabled();
      t_debounce();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule